// File: doc/BRIEF.md
# Transmit Collision Statistics Register

This block keeps a running tally of transmit collisions for a network MAC. Each time the collision detector pulses for one cycle, a ten-bit tally goes up by one. The host reads a sixteen-bit word. The tally sits in the upper ten bits of that word. The lower six bits always carry a fixed tag, so software can tell which register it has read. A read hands the host the current tally and clears it, so each read returns the collisions seen since the previous read.

The tally wraps back to zero after its largest value. Before that happens, the block can raise an interrupt request when the tally first reaches the midpoint of its range. This gives software half the range of further events in which to read the register before any count is lost. The interrupt is only raised when the enable bit from the buffer configuration logic is set. Once raised, the request stays high until the host reads the register.

Top module: `collision_count_reg`

## Requirements
- R1: Bits 15..6 of `rdWord` always show the current tally (bit 6 is the tally's LSB).
- R2: Bits 5..0 of `rdWord` always read the constant 6'b010010 (bit 0 is a 0, bit 1 is a 1, bit 4 is a 1).
- R3: A `colPulse` in a cycle without `hostRd` raises the tally by exactly one at the next clock edge. With neither input high, the tally holds.
- R4: A `colPulse` when the tally is 0x3FF, with no read in that cycle, wraps the tally to 0.
- R5: A host read works as follows. In the cycle `hostRd` is high, `rdWord` shows the tally as it was before that cycle. If `colPulse` is low in that cycle, the tally is 0 after the clock edge.
- R6: After reset, `rdWord` is 0x0012 and `irqReq` is low.
- R7: When `hostRd` and `colPulse` are high in the same cycle, the word returned in that cycle does not include this event, and the tally is 1 after the edge.
- R8: When `irqEnable` is high and a `colPulse` moves the tally from 0x1FF to 0x200, `irqReq` goes high at that clock edge.
- R9: Once high, `irqReq` stays high across further collisions and across a wrap. It goes low at the edge that ends a `hostRd` cycle.
- R10: When `irqEnable` is low at the 0x1FF to 0x200 step, `irqReq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| colPulse | input | 1 | One-cycle pulse for each transmit collision |
| irqEnable | input | 1 | Enables the midpoint interrupt |
| hostRd | input | 1 | Host read strobe; clears the tally |
| rdWord | output | 16 | Tally in bits 15..6, fixed tag in bits 5..0 |
| irqReq | output | 1 | Sticky midpoint-warning interrupt request |

## Verification
The checks assume that each collision is a single-cycle pulse sampled at a clock edge. They also assume that the enable bit is valid in the cycle of the midpoint step. `hostRd` may coincide with a collision, and the properties cover that overlap directly. The stimulus draws collisions, reads and enable changes from a fixed-seed random source, so all of these combinations occur. Directed runs then drive long unread bursts past the midpoint and across the wrap, with the enable both set and clear. These exercise cases that random reads would almost always interrupt.

// File: rtl/collision_cnt_pkg.sv
package collision_cnt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero the tally (host read)
    logic seedOne;  // with clear: restart at one instead of zero
    logic step;     // add one to the tally
  } cntStrobes_t;
endpackage

// File: rtl/collision_count_ctrl.sv
module collision_count_ctrl
  import collision_cnt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        colPulse,
  input  logic        irqEnable,
  input  logic        hostRd,
  input  logic        atPreHalf,
  output cntStrobes_t strobes,
  output logic        irqReq
);
  logic irqFlag;

  always_comb begin
    strobes.clear   = hostRd;
    strobes.seedOne = hostRd & colPulse;
    strobes.step    = colPulse & ~hostRd;
  end

  // sticky warning: set on the midpoint step, dropped by a read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqFlag <= 1'b0;
    else if (hostRd)
      irqFlag <= 1'b0;
    else if (strobes.step && atPreHalf && irqEnable)
      irqFlag <= 1'b1;
  end

  assign irqReq = irqFlag;
endmodule

// File: rtl/collision_count_path.sv
module collision_count_path
  import collision_cnt_pkg::*;
#(
  parameter int          CNT_W   = 10,
  parameter int          ID_W    = 6,
  parameter logic [ID_W-1:0] ID_CODE = 6'b010010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cntStrobes_t           strobes,
  output logic [CNT_W+ID_W-1:0] rdWord,
  output logic                  atPreHalf
);
  localparam logic [CNT_W-1:0] PRE_HALF = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] tally;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tally <= '0;
    else if (strobes.clear)
      tally <= strobes.seedOne ? ONE : '0;
    else if (strobes.step)
      tally <= tally + ONE;  // wraps naturally at full range
  end

  assign atPreHalf = (tally == PRE_HALF);
  assign rdWord    = {tally, ID_CODE};
endmodule

// File: rtl/collision_count_reg.sv
module collision_count_reg
  import collision_cnt_pkg::*;
#(
  parameter int          CNT_W   = 10,
  parameter int          ID_W    = 6,
  parameter logic [ID_W-1:0] ID_CODE = 6'b010010,
  localparam int         WORD_W  = CNT_W + ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colPulse,
  input  logic              irqEnable,
  input  logic              hostRd,
  output logic [WORD_W-1:0] rdWord,
  output logic              irqReq
);
  cntStrobes_t strobes;
  logic        atPreHalf;

  collision_count_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .colPulse  (colPulse),
    .irqEnable (irqEnable),
    .hostRd    (hostRd),
    .atPreHalf (atPreHalf),
    .strobes   (strobes),
    .irqReq    (irqReq)
  );

  collision_count_path #(
    .CNT_W   (CNT_W),
    .ID_W    (ID_W),
    .ID_CODE (ID_CODE)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdWord    (rdWord),
    .atPreHalf (atPreHalf)
  );
endmodule

// File: rtl/collision_count_reg_chk.sv
module collision_count_reg_chk #(
  parameter int          CNT_W   = 10,
  parameter int          ID_W    = 6,
  parameter logic [ID_W-1:0] ID_CODE = 6'b010010
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  colPulse,
  input logic                  irqEnable,
  input logic                  hostRd,
  input logic [CNT_W+ID_W-1:0] rdWord,
  input logic                  irqReq
);
  localparam logic [CNT_W-1:0] PRE_HALF = CNT_W'((1 << (CNT_W - 1)) - 1);
  logic [CNT_W-1:0] cnt;
  assign cnt = rdWord[CNT_W+ID_W-1:ID_W];

  p_tag_field_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdWord[ID_W-1:0] == ID_CODE);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (colPulse && !hostRd) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!colPulse && !hostRd) |=> $stable(cnt));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (colPulse && !hostRd && (&cnt)) |=> cnt == '0);

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !colPulse) |=> cnt == '0);

  p_read_with_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && colPulse) |=> cnt == CNT_W'(1));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($past(cnt) == PRE_HALF && $past(colPulse) && $past(irqEnable)));

  p_irq_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (colPulse && !hostRd && irqEnable && cnt == PRE_HALF) |=> irqReq);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !hostRd) |=> irqReq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> !irqReq);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && !irqEnable) |=> !irqReq);
endmodule

bind collision_count_reg collision_count_reg_chk #(
  .CNT_W   (CNT_W),
  .ID_W    (ID_W),
  .ID_CODE (ID_CODE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .colPulse  (colPulse),
  .irqEnable (irqEnable),
  .hostRd    (hostRd),
  .rdWord    (rdWord),
  .irqReq    (irqReq)
);

// File: tb/collision_count_reg_test.sv
module collision_count_reg_test;
  localparam logic [5:0] TAG = 6'b010010;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        colPulse = 1'b0;
  logic        irqEnable = 1'b0;
  logic        hostRd = 1'b0;
  logic [15:0] rdWord;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] mCnt = '0;
  logic       mIrq = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  collision_count_reg uut (
    .clk(clk), .rstN(rstN), .colPulse(colPulse),
    .irqEnable(irqEnable), .hostRd(hostRd),
    .rdWord(rdWord), .irqReq(irqReq)
  );

  function automatic logic [15:0] expWord(logic [9:0] c);
    return {c, TAG};  // R1 R2
  endfunction

  function automatic logic [9:0] nextCnt(logic [9:0] c, logic p, logic r);
    if (r) return p ? 10'd1 : 10'd0;   // R5 R7
    if (p) return c + 10'd1;           // R3 R4
    return c;
  endfunction

  function automatic logic nextIrq(logic i, logic [9:0] c, logic p, logic r, logic e);
    if (r) return 1'b0;                                     // R9
    if (p && e && c == 10'h1FF) return 1'b1;                // R8 R10
    return i;
  endfunction

  task automatic chkWord(string tag, logic [15:0] exp);
    checks++;
    if (rdWord !== exp) begin
      errors++;
      $display("FAIL %s rdWord actual %h expected %h", tag, rdWord, exp);
    end
  endtask

  task automatic chkIrq(string tag, logic exp);
    checks++;
    if (irqReq !== exp) begin
      errors++;
      $display("FAIL %s irqReq actual %b expected %b", tag, irqReq, exp);
    end
  endtask

  // called at a falling edge: drive, check the read word, clock, check state
  task automatic step(logic p, logic r, logic e);
    string t;
    colPulse = p; hostRd = r; irqEnable = e;
    if (r) chkWord(p ? "R7" : "R5", expWord(mCnt));
    @(posedge clk);
    mIrq = nextIrq(mIrq, mCnt, p, r, e);
    mCnt = nextCnt(mCnt, p, r);
    @(negedge clk);
    t = r ? (p ? "R7" : "R5") : (p ? "R3" : "R1");
    chkWord(t, expWord(mCnt));
    chkIrq(r ? "R9" : (e ? "R8" : "R10"), mIrq);
    colPulse = 1'b0; hostRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R6 reset state
    chkWord("R6", 16'h0012);
    chkIrq("R6", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkWord("R6", 16'h0012);
    chkIrq("R6", 1'b0);

    // directed: climb to the midpoint with enable set (R8)
    for (int k = 0; k < 511; k++) step(1'b1, 1'b0, 1'b1);
    chkWord("R1", {10'h1FF, TAG});
    chkIrq("R8", 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chkIrq("R8", 1'b1);
    // continue to full range and wrap, irq sticky (R4 R9)
    for (int k = 0; k < 511; k++) step(1'b1, 1'b0, 1'b0);
    chkWord("R4", {10'h3FF, TAG});
    step(1'b1, 1'b0, 1'b1);
    chkWord("R4", {10'h000, TAG});
    chkIrq("R9", 1'b1);
    step(1'b0, 1'b1, 1'b1);  // read clears irq (R9)
    chkIrq("R9", 1'b0);

    // directed: crossing with enable clear (R10)
    for (int k = 0; k < 512; k++) step(1'b1, 1'b0, 1'b0);
    chkWord("R10", {10'h200, TAG});
    chkIrq("R10", 1'b0);

    // directed: read coinciding with a collision (R7)
    step(1'b1, 1'b1, 1'b0);
    chkWord("R7", {10'd1, TAG});
    step(1'b0, 1'b0, 1'b0);  // idle hold (R3)
    step(1'b0, 1'b1, 1'b0);  // plain read (R5)

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      logic p, r, e;
      p = ($urandom % 100) < 70;
      r = ($urandom % 400) == 0;
      e = ($urandom % 8) != 0;
      step(p, r, e);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule